// File: doc/BRIEF.md
# CAN Transmit Interrupt and Error-State Monitor

This block sits beside the transmit path of a CAN controller and turns what happens there into interrupt flags. Three transmit buffers each report whether they hold a scheduled message. When a buffer drops from scheduled to empty, the block latches a flag for that buffer, so software can see which slot is free to reload.

The block also holds the transmit error counter. The protocol engine drives it with two strobes: one for a failed transmission and one for a successful one. Three condition levels come from the counter value: warning, error-passive and bus-off. The block latches a sticky flag when the counter enters each of these conditions. A summary error flag collects every such entry, together with receive-side error events that arrive on a separate input.

All latched flags share one write-one-to-clear port. Bus-off recovery is outside the block. It is modelled by a recovery input that zeroes the counter.

Top module: `can_tx_event_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `tec_o`, `buf_irq_o`, `err_irq_o`, `stat_flags_o`, `warn_o`, `passive_o` and `busoff_o` are all zero.
- R2: Bit i of `buf_irq_o` becomes 1 one clock after the edge where `buf_busy_i[i]` was 1 and is sampled 0 (scheduled to empty). A buffer that stays empty, stays busy, or goes from empty to busy sets nothing.
- R3: A write with `clr_wr_i` high clears each latched flag whose bit in `clr_mask_i` is 1. The mask bits are: 0..2 for buffers 0..2, 3 for the error summary, 4 for warning, 5 for error-passive and 6 for bus-off. Flags whose mask bit is 0 keep their value. If a flag is set and cleared in the same cycle, the set wins.
- R4: A `tx_err_stb_i` pulse outside bus-off adds 8 to `tec_o` at the next edge.
- R5: A `tx_ok_stb_i` pulse outside bus-off subtracts 1, and the counter never goes below 0. When both strobes arrive in one cycle the net change is +7.
- R6: `warn_o` is 1 while `tec_o` >= 96, `passive_o` is 1 while `tec_o` > 127, and `busoff_o` is 1 while `tec_o` > 255.
- R7: `stat_flags_o` bit 0 (warning), bit 1 (error-passive) and bit 2 (bus-off) are set only on the edge where the counter enters that condition. A flag cleared while its condition still holds stays clear.
- R8: `err_irq_o` is set one clock after any condition entry, or after an `rx_err_evt_i` pulse.
- R9: In bus-off the counter ignores both strobes and holds its value. A `recover_i` pulse sets `tec_o` to 0 at the next edge in any state (it has priority over the strobes) and leaves the latched flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| recover_i | input | 1 | External recovery pulse that zeroes the counter |
| buf_busy_i | input | 3 | Per-buffer scheduled indication (1 = message pending) |
| tx_err_stb_i | input | 1 | Transmit error strobe (+8) |
| tx_ok_stb_i | input | 1 | Successful transmit strobe (-1) |
| rx_err_evt_i | input | 1 | Receive-side error event feeding the summary flag |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 7 | Flags to clear, using the bit layout of R3 |
| buf_irq_o | output | 3 | Latched per-buffer availability flags |
| err_irq_o | output | 1 | Latched summary error flag |
| stat_flags_o | output | 3 | Latched entry flags: warning, error-passive, bus-off |
| tec_o | output | 9 | Transmit error counter |
| warn_o | output | 1 | Warning level |
| passive_o | output | 1 | Error-passive level |
| busoff_o | output | 1 | Bus-off level |

## Verification
The hardest state to reach from the ports is bus-off, together with the freeze that follows it. Getting there takes at least 32 net error strobes, and any success strobes in between pull the counter back down. The bench therefore ramps the counter in a directed sequence, sending success strobes while in bus-off and then recovering. It then runs random phases whose error bias changes, so that the warning and error-passive thresholds are crossed in both directions and bus-off is entered several times. Recovery pulses are drawn only while the counter is in bus-off.

// File: rtl/can_txmon_pkg.sv
package can_txmon_pkg;

  localparam int unsigned ST_WARN    = 0;
  localparam int unsigned ST_PASSIVE = 1;
  localparam int unsigned ST_BUSOFF  = 2;
  localparam int unsigned ST_W       = 3;

  // one counter update: optional increment with ceiling, then optional decrement with floor
  function automatic logic [31:0] tec_step(input logic [31:0] cur, input logic inc,
                                           input logic dec, input logic [31:0] step,
                                           input logic [31:0] ceil);
    logic [31:0] v;
    v = inc ? cur + step : cur;
    if (v > ceil) v = ceil;
    if (dec && v != 32'd0) v = v - 32'd1;
    return v;
  endfunction

  // level classification of a counter value
  function automatic logic [ST_W-1:0] classify(input logic [31:0] tec, input logic [31:0] warn_lvl,
                                               input logic [31:0] passive_lvl,
                                               input logic [31:0] busoff_lvl);
    logic [ST_W-1:0] s;
    s[ST_WARN]    = (tec >= warn_lvl);
    s[ST_PASSIVE] = (tec >= passive_lvl);
    s[ST_BUSOFF]  = (tec >= busoff_lvl);
    return s;
  endfunction

endpackage

// File: rtl/txmon_err_counter.sv
module txmon_err_counter
  import can_txmon_pkg::*;
#(
  parameter int unsigned TEC_W       = 9,
  parameter int unsigned INC_STEP    = 8,
  parameter int unsigned WARN_LVL    = 96,
  parameter int unsigned PASSIVE_LVL = 128,
  parameter int unsigned BUSOFF_LVL  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [ST_W-1:0]  level_o,
  output logic [ST_W-1:0]  enter_o
);

  localparam logic [31:0] TEC_MAX = 32'((64'd1 << TEC_W) - 64'd1);

  logic [TEC_W-1:0] tec_q;
  logic [TEC_W-1:0] tec_d;
  logic [ST_W-1:0]  cur_lvl;
  logic [ST_W-1:0]  nxt_lvl;
  logic             frozen;

  assign cur_lvl = classify(32'(tec_q), WARN_LVL, PASSIVE_LVL, BUSOFF_LVL);
  assign frozen  = cur_lvl[ST_BUSOFF];

  always_comb begin
    if (recover_i)   tec_d = '0;
    else if (frozen) tec_d = tec_q;
    else             tec_d = TEC_W'(tec_step(32'(tec_q), inc_i, dec_i, INC_STEP, TEC_MAX));
  end

  assign nxt_lvl = classify(32'(tec_d), WARN_LVL, PASSIVE_LVL, BUSOFF_LVL);
  assign enter_o = nxt_lvl & ~cur_lvl;
  assign level_o = cur_lvl;
  assign tec_o   = tec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tec_q <= '0;
    else        tec_q <= tec_d;
  end

  assert_busoff_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl[ST_BUSOFF] && !recover_i) |=> $stable(tec_q));

  assert_recover_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recover_i |=> (tec_q == '0));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_q == '0 && dec_i && !inc_i && !recover_i) |=> (tec_q == '0));

  assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !recover_i && !cur_lvl[ST_BUSOFF] && 32'(tec_q) + INC_STEP <= TEC_MAX)
      |=> (32'(tec_q) == 32'($past(tec_q)) + INC_STEP));

  assert_single_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enter_o));

endmodule

// File: rtl/txmon_buf_edge.sv
module txmon_buf_edge #(
  parameter int unsigned NBUF = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] busy_i,
  output logic [NBUF-1:0] freed_o
);

  logic [NBUF-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_i;
  end

  assign freed_o = busy_q & ~busy_i;

endmodule

// File: rtl/txmon_w1c_bank.sv
module txmon_w1c_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        flag_q <= 1'b0;
      else if (set_i[g])                 flag_q <= 1'b1;
      else if (clr_wr_i && clr_mask_i[g]) flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);

    assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && clr_mask_i[g] && !set_i[g]) |=> !flag_o[g]);

    assert_hold_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[g] && !(clr_wr_i && clr_mask_i[g])) |=> $stable(flag_o[g]));
  end

endmodule

// File: rtl/can_tx_event_monitor.sv
module can_tx_event_monitor
  import can_txmon_pkg::*;
#(
  parameter int unsigned NBUF        = 3,
  parameter int unsigned TEC_W       = 9,
  parameter int unsigned INC_STEP    = 8,
  parameter int unsigned WARN_LVL    = 96,
  parameter int unsigned PASSIVE_LVL = 128,
  parameter int unsigned BUSOFF_LVL  = 256,
  localparam int unsigned NFLAG      = NBUF + 1 + ST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_i,
  input  logic [NBUF-1:0]  buf_busy_i,
  input  logic             tx_err_stb_i,
  input  logic             tx_ok_stb_i,
  input  logic             rx_err_evt_i,
  input  logic             clr_wr_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  output logic [NBUF-1:0]  buf_irq_o,
  output logic             err_irq_o,
  output logic [ST_W-1:0]  stat_flags_o,
  output logic [TEC_W-1:0] tec_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o
);

  logic [NBUF-1:0]  buf_freed;
  logic [ST_W-1:0]  lvl;
  logic [ST_W-1:0]  lvl_enter;
  logic             err_set;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flags;

  txmon_err_counter #(
    .TEC_W(TEC_W), .INC_STEP(INC_STEP), .WARN_LVL(WARN_LVL),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .recover_i(recover_i),
    .inc_i(tx_err_stb_i), .dec_i(tx_ok_stb_i),
    .tec_o(tec_o), .level_o(lvl), .enter_o(lvl_enter)
  );

  txmon_buf_edge #(.NBUF(NBUF)) u_edge (
    .clk(clk), .rst_n(rst_n), .busy_i(buf_busy_i), .freed_o(buf_freed)
  );

  assign err_set  = (|lvl_enter) | rx_err_evt_i;
  assign flag_set = {lvl_enter, err_set, buf_freed};

  txmon_w1c_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set),
    .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i), .flag_o(flags)
  );

  assign buf_irq_o    = flags[NBUF-1:0];
  assign err_irq_o    = flags[NBUF];
  assign stat_flags_o = flags[NFLAG-1:NBUF+1];
  assign warn_o       = lvl[ST_WARN];
  assign passive_o    = lvl[ST_PASSIVE];
  assign busoff_o     = lvl[ST_BUSOFF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bufchk
    assert_buf_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_freed[b] |=> buf_irq_o[b]);
  end

  assert_entry_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_enter) |=> err_irq_o);

  assert_rx_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt_i |=> err_irq_o);

  assert_passive_implies_warn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    passive_o |-> warn_o);

  assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff_o) |-> stat_flags_o[ST_BUSOFF]);

endmodule

// File: tb/can_tx_event_monitor_tb.sv
module can_tx_event_monitor_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       recover = 1'b0;
  logic [2:0] busy = 3'b000;
  logic       err_stb = 1'b0;
  logic       ok_stb = 1'b0;
  logic       rx_evt = 1'b0;
  logic       clr_wr = 1'b0;
  logic [6:0] clr_mask = 7'd0;

  logic [2:0] buf_irq;
  logic       err_irq;
  logic [2:0] stat_flags;
  logic [8:0] tec;
  logic       warn, passive, busoff;

  int n_checks = 0;
  int n_errors = 0;

  int         m_tec = 0;
  logic [6:0] m_flags = 7'd0;
  logic [2:0] m_busy_prev = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_event_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .recover_i(recover), .buf_busy_i(busy),
    .tx_err_stb_i(err_stb), .tx_ok_stb_i(ok_stb), .rx_err_evt_i(rx_evt),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask),
    .buf_irq_o(buf_irq), .err_irq_o(err_irq), .stat_flags_o(stat_flags),
    .tec_o(tec), .warn_o(warn), .passive_o(passive), .busoff_o(busoff)
  );

  function automatic int tec_next(int t, bit e, bit o, bit rec);
    int n;
    if (rec) return 0;
    if (t > 255) return t;
    n = t;
    if (e) n = n + 8;
    if (n > 511) n = 511;
    if (o && n > 0) n = n - 1;
    return n;
  endfunction

  function automatic logic [2:0] levels(int t);
    return {t > 255, t > 127, t >= 96};
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int nt;
    logic [2:0] ent;
    logic [6:0] setv, clrv;
    if (!rst_n) begin
      m_tec = 0; m_flags = 7'd0; m_busy_prev = 3'b000;
    end else begin
      nt   = tec_next(m_tec, err_stb, ok_stb, recover);
      ent  = levels(nt) & ~levels(m_tec);
      setv = {ent, (|ent) | rx_evt, m_busy_prev & ~busy};
      clrv = clr_wr ? clr_mask : 7'd0;
      m_flags = (m_flags & ~clrv) | setv;
      m_tec = nt;
      m_busy_prev = busy;
    end
  endtask

  task automatic compare_all();
    check("R2 R3 buffer flags", int'(buf_irq), int'(m_flags[2:0]));
    check("R8 R3 error summary", int'(err_irq), int'(m_flags[3]));
    check("R7 R3 entry flags", int'(stat_flags), int'(m_flags[6:4]));
    check("R4 R5 R9 counter", int'(tec), m_tec);
    check("R6 levels", int'({busoff, passive, warn}), int'(levels(m_tec)));
  endtask

  // called at a falling edge with inputs already set
  task automatic cycle();
    @(posedge clk);
    model_update();
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic quiet();
    err_stb = 0; ok_stb = 0; recover = 0; rx_evt = 0; clr_wr = 0; clr_mask = 7'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    busy = 3'b111; err_stb = 1;
    @(negedge clk);
    repeat (3) cycle();
    check("R1 reset tec", int'(tec), 0);
    check("R1 reset flags", int'({buf_irq, err_irq, stat_flags}), 0);
    check("R1 reset levels", int'({busoff, passive, warn}), 0);
    quiet(); busy = 3'b000;
    rst_n = 1;
    cycle();
    check("R1 first cycle flags", int'({buf_irq, err_irq, stat_flags, tec}), 0);

    // R2: scheduled -> empty on buffers 0 and 2
    busy = 3'b111; cycle();
    busy = 3'b010; cycle();
    check("R2 freed buffers 0 and 2", int'(buf_irq), 3'b101);
    busy = 3'b010; cycle();
    busy = 3'b011; cycle();   // empty -> busy sets nothing
    check("R2 no set on load", int'(buf_irq), 3'b101);
    // R3: partial clear, and set wins over clear on buffer 1
    busy = 3'b001; clr_wr = 1; clr_mask = 7'b0000011; cycle();
    quiet();
    check("R3 partial clear and set wins", int'(buf_irq), 3'b110);
    busy = 3'b000; cycle();

    // ramp to warning: 12 error strobes -> 96
    err_stb = 1;
    repeat (12) cycle();
    err_stb = 0;
    check("R6 warning at 96", int'({passive, warn}), 2'b01);
    check("R7 warning entry", int'(stat_flags), 3'b001);
    check("R8 error summary on entry", int'(err_irq), 1);
    clr_wr = 1; clr_mask = 7'b1111111; cycle(); quiet();
    err_stb = 1; ok_stb = 1; cycle(); quiet();   // +7 while still in warning
    check("R7 no refire while held", int'(stat_flags), 3'b000);
    check("R5 both strobes net +7", int'(tec), 103);
    // to passive then bus-off
    err_stb = 1;
    repeat (20) cycle();
    err_stb = 0;
    check("R6 bus-off level", int'(busoff), 1);
    check("R7 passive and bus-off entries", int'(stat_flags), 3'b110);
    // R9: frozen in bus-off
    ok_stb = 1; repeat (5) cycle();
    err_stb = 1; repeat (3) cycle(); quiet();
    check("R9 frozen counter", int'(tec), 263);
    recover = 1; cycle(); quiet();
    check("R9 recover zeroes counter", int'(tec), 0);
    check("R9 flags kept after recover", int'(stat_flags), 3'b110);

    // R5: floor at zero
    ok_stb = 1; repeat (3) cycle(); quiet();
    check("R5 floor at zero", int'(tec), 0);
    // R8: receive-side event
    clr_wr = 1; clr_mask = 7'b0001000; cycle(); quiet();
    rx_evt = 1; cycle(); quiet();
    check("R8 receive event sets summary", int'(err_irq), 1);

    // random phases with changing error bias
    void'($urandom(32'd4242));
    for (int ph = 0; ph < 16; ph++) begin
      for (int k = 0; k < 250; k++) begin
        int bias;
        bias = (ph % 2 == 0) ? 3 : 12;
        busy     = 3'($urandom_range(0, 7));
        err_stb  = ($urandom_range(0, bias) == 0);
        ok_stb   = ($urandom_range(0, 1) == 0);
        rx_evt   = ($urandom_range(0, 40) == 0);
        recover  = (m_tec > 255) && ($urandom_range(0, 20) == 0);
        clr_wr   = ($urandom_range(0, 5) == 0);
        clr_mask = 7'($urandom_range(0, 127));
        cycle();
      end
    end
    quiet();
    cycle();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule